// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead-Time Insertion

This block is a single PWM output channel driven from a shared up/down time base. Comparator A watches the selected time-base bus. Comparator B watches a private dead-time counter. That counter restarts from 1 on every real A match, so B measures a programmable delay that follows an A event. The channel can work in trail mode or in lead mode. In trail mode it makes the active edge at once on one A match, and it delays the return to idle by the dead time after the next A match. In lead mode it delays the active edge by the dead time and ends the pulse at once on the next A match. An edge-polarity input selects which level counts as active.

Software loads both compare values into holding registers. The values reach the comparators only at a period boundary, which is the clock edge where the time base reads 1. A sticky event flag records output edges. It can record only the trailing edges or every edge. Two force strobes put the output straight into a fixed level without behaving like a match.

Top module: `pwm_dt_center`

## Requirements
- R1: While reset is asserted, `pwmOut` is 0, `flag` is 0, both active compare values are 0, and the dead-time counter sits at all-ones.
- R2: A write to `wrA` or `wrB` changes only the holding copy. The active copy takes the holding value on the clock edge where `timeBase` equals 1, and at no other edge.
- R3: On every edge where `timeBase` equals the active A value, the dead-time counter loads 1. A pending delayed edge then takes place exactly (active B) clock edges after that A edge.
- R4: Trail mode (`leadMode`=0). When an A match finds the output inactive, the output goes to the active level (`edgePol`) on that edge. When an A match finds the output active, the return to `~edgePol` is armed and happens on the B match. A further A match while armed restarts the delay.
- R5: Lead mode (`leadMode`=1). When an A match finds the output inactive, a rise to `edgePol` is armed and happens on the B match. When an A match finds the output active, the output goes to `~edgePol` on that edge and any pending edge is dropped.
- R6: With `flagBoth`=0, only a match-driven change to `~edgePol` sets `flag`. With `flagBoth`=1, any match-driven output change sets it. `flag` stays 1 until a `flagClr` pulse, and a set in the same cycle wins over the clear.
- R7: Output edges keep being produced on later A and B matches whether or not `flag` has been cleared.
- R8: `forceA` sets the output to `~edgePol` in lead mode and to `edgePol` in trail mode, on the next edge.
- R9: `forceB` (when `forceA` is low) sets the output to `edgePol` in lead mode and to `~edgePol` in trail mode, on the next edge.
- R10: A force takes priority over any match in the same cycle. It drops any pending delayed edge, never sets `flag`, and does not reload the dead-time counter.
- R11: The dead-time counter saturates at all-ones and does not wrap. With an active B value of 0, a pending delayed edge never happens while no A match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| timeBase | input | TB_W | Selected up/down time-base bus |
| wrA | input | 1 | Write strobe for the A holding register |
| wrB | input | 1 | Write strobe for the B holding register (dead-time length) |
| wrData | input | TB_W | Data for the holding-register writes |
| leadMode | input | 1 | 1 = dead time on the leading edge, 0 = on the trailing edge |
| edgePol | input | 1 | Active output level |
| flagBoth | input | 1 | 1 = flag on both edges, 0 = on trailing edges only |
| forceA | input | 1 | Force strobe A |
| forceB | input | 1 | Force strobe B |
| flagClr | input | 1 | Write-one-to-clear pulse for the flag |
| pwmOut | output | 1 | PWM output |
| flag | output | 1 | Sticky event flag |

## Verification
The bench builds the channel with `TB_W` = 8, so the dead-time counter reaches its all-ones limit within a few hundred cycles. This lets the bench show that an armed edge with a B value of 0 never happens, where a wrapping counter would cause one. With the narrow time base, triangle sweeps with peaks of 20 to 25 give two A matches per period. This runs both modes, both polarities, several dead-time lengths and the compare-value reload at the boundary in short runs. A behavioural model in the bench predicts the output and the flag on every clock.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;     // restart dead-time counter at 1
    logic advanceCnt;  // step dead-time counter (saturating)
  } cntCtlT;

  // Comparator results from datapath to control
  typedef struct packed {
    logic hitA;        // time base equals active A
    logic hitB;        // dead-time counter equals active B
  } cmpHitT;

endpackage

// File: rtl/pwm_dt_datapath.sv
module pwm_dt_datapath
  import pwm_dt_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [TB_W-1:0] timeBase,
  input  logic            wrA,
  input  logic            wrB,
  input  logic [TB_W-1:0] wrData,
  input  cntCtlT          ctl,
  output cmpHitT          hit
);

  localparam int NUM_CMP = 2;
  localparam logic [TB_W-1:0] CNT_MAX = {TB_W{1'b1}};
  localparam logic [TB_W-1:0] BOUNDARY = TB_W'(1);

  logic [NUM_CMP-1:0]           wrVec;
  logic [NUM_CMP-1:0][TB_W-1:0] holdQ;
  logic [NUM_CMP-1:0][TB_W-1:0] actQ;
  logic [TB_W-1:0]              dtCnt;
  logic                         atBoundary;

  assign wrVec      = {wrB, wrA};
  assign atBoundary = (timeBase == BOUNDARY);

  // Two-stage compare registers, one slice per comparator
  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmpReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdQ[g] <= '0;
        actQ[g]  <= '0;
      end else begin
        if (wrVec[g])   holdQ[g] <= wrData;
        if (atBoundary) actQ[g]  <= holdQ[g];
      end
    end
  end

  // Private dead-time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dtCnt <= CNT_MAX;
    end else if (ctl.loadCnt) begin
      dtCnt <= TB_W'(1);
    end else if (ctl.advanceCnt && (dtCnt != CNT_MAX)) begin
      dtCnt <= dtCnt + TB_W'(1);
    end
  end

  assign hit.hitA = (timeBase == actQ[0]);
  assign hit.hitB = (dtCnt == actQ[1]);

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !atBoundary |=> $stable(actQ)); // R2

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    hit.hitA |=> (dtCnt == TB_W'(1))); // R3

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (dtCnt == CNT_MAX) && !hit.hitA |=> (dtCnt == CNT_MAX)); // R11

endmodule

// File: rtl/pwm_dt_control.sv
module pwm_dt_control
  import pwm_dt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  cmpHitT hit,
  input  logic   leadMode,
  input  logic   edgePol,
  input  logic   flagBoth,
  input  logic   forceA,
  input  logic   forceB,
  input  logic   flagClr,
  output cntCtlT ctl,
  output logic   pwmOut,
  output logic   flag
);

  logic outQ, outN;
  logic armQ, armN;
  logic flagQ, flagN;
  logic byMatch;
  logic isActive;
  logic delayedHit;
  logic matchEdge;
  logic flagSet;

  assign isActive   = (outQ == edgePol);
  assign delayedHit = hit.hitB && armQ;

  // Next output level and arm state; force beats match
  always_comb begin
    outN    = outQ;
    armN    = armQ;
    byMatch = 1'b0;
    if (forceA) begin
      outN = leadMode ? ~edgePol : edgePol;
      armN = 1'b0;
    end else if (forceB) begin
      outN = leadMode ? edgePol : ~edgePol;
      armN = 1'b0;
    end else if (hit.hitA) begin
      byMatch = 1'b1;
      if (!leadMode) begin
        if (!isActive) outN = edgePol;
        else           armN = 1'b1;
      end else begin
        if (isActive) begin
          outN = ~edgePol;
          armN = 1'b0;
        end else begin
          armN = 1'b1;
        end
      end
    end else if (delayedHit) begin
      byMatch = 1'b1;
      outN    = leadMode ? edgePol : ~edgePol;
      armN    = 1'b0;
    end
  end

  assign matchEdge = byMatch && (outN != outQ);
  assign flagSet   = matchEdge && (flagBoth || (outN != edgePol));
  assign flagN     = flagSet || (flagQ && !flagClr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= 1'b0;
      armQ  <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      outQ  <= outN;
      armQ  <= armN;
      flagQ <= flagN;
    end
  end

  assign ctl.loadCnt    = hit.hitA;
  assign ctl.advanceCnt = !hit.hitA;
  assign pwmOut         = outQ;
  assign flag           = flagQ;

  AST_FORCE_A_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    forceA |=> (pwmOut == ($past(leadMode) ? ~$past(edgePol) : $past(edgePol)))); // R8

  AST_FORCE_B_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    forceB && !forceA |=> (pwmOut == ($past(leadMode) ? $past(edgePol) : ~$past(edgePol)))); // R9

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (forceA || forceB) && !flagQ |=> !flagQ); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !flagClr |=> flagQ); // R6

  AST_LEAD_EDGE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !flagBoth && !flagQ && (outN == edgePol) |=> !flagQ); // R6

endmodule

// File: rtl/pwm_dt_center.sv
module pwm_dt_center
  import pwm_dt_pkg::*;
#(
  parameter int TB_W = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [TB_W-1:0] timeBase,
  input  logic            wrA,
  input  logic            wrB,
  input  logic [TB_W-1:0] wrData,
  input  logic            leadMode,
  input  logic            edgePol,
  input  logic            flagBoth,
  input  logic            forceA,
  input  logic            forceB,
  input  logic            flagClr,
  output logic            pwmOut,
  output logic            flag
);

  cntCtlT ctl;
  cmpHitT hit;

  pwm_dt_datapath #(.TB_W(TB_W)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .timeBase (timeBase),
    .wrA      (wrA),
    .wrB      (wrB),
    .wrData   (wrData),
    .ctl      (ctl),
    .hit      (hit)
  );

  pwm_dt_control uControl (
    .clk      (clk),
    .rstN     (rstN),
    .hit      (hit),
    .leadMode (leadMode),
    .edgePol  (edgePol),
    .flagBoth (flagBoth),
    .forceA   (forceA),
    .forceB   (forceB),
    .flagClr  (flagClr),
    .ctl      (ctl),
    .pwmOut   (pwmOut),
    .flag     (flag)
  );

endmodule

// File: tb/tb_pwm_dt_center.sv
module tb_pwm_dt_center;

  localparam int W    = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] timeBase;
  logic         wrA, wrB;
  logic [W-1:0] wrData;
  logic         leadMode, edgePol, flagBoth;
  logic         forceA, forceB, flagClr;
  logic         pwmOut, flag;

  int errors = 0;
  int checks = 0;
  int edgesSeen = 0;
  logic prevOut = 1'b0;
  string curReq = "R1";

  always #2 clk = ~clk;  // 250 MHz

  pwm_dt_center #(.TB_W(W)) dut (
    .clk(clk), .rstN(rstN), .timeBase(timeBase), .wrA(wrA), .wrB(wrB),
    .wrData(wrData), .leadMode(leadMode), .edgePol(edgePol),
    .flagBoth(flagBoth), .forceA(forceA), .forceB(forceB),
    .flagClr(flagClr), .pwmOut(pwmOut), .flag(flag)
  );

  // Behavioural reference model
  int   mHoldA, mHoldB, mActA, mActB, mCnt;
  logic mOut, mArm, mFlag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHoldA = 0; mHoldB = 0; mActA = 0; mActB = 0;
      mCnt = MAXV; mOut = 1'b0; mArm = 1'b0; mFlag = 1'b0;
    end else begin
      bit   a, b, viaMatch;
      logic nOut, nArm;
      a = (int'(timeBase) == mActA);
      b = mArm && (mCnt == mActB);
      nOut = mOut; nArm = mArm; viaMatch = 0;
      if (forceA) begin
        nOut = leadMode ? !edgePol : edgePol; nArm = 0;
      end else if (forceB) begin
        nOut = leadMode ? edgePol : !edgePol; nArm = 0;
      end else if (a) begin
        viaMatch = 1;
        if (mOut == edgePol) begin
          if (leadMode) begin nOut = !edgePol; nArm = 0; end
          else nArm = 1;
        end else begin
          if (leadMode) nArm = 1;
          else nOut = edgePol;
        end
      end else if (b) begin
        viaMatch = 1;
        nOut = leadMode ? edgePol : !edgePol; nArm = 0;
      end
      if (viaMatch && (nOut != mOut) && (flagBoth || nOut != edgePol)) mFlag = 1;
      else if (flagClr) mFlag = 0;
      if (a) mCnt = 1;
      else if (mCnt < MAXV) mCnt = mCnt + 1;
      if (int'(timeBase) == 1) begin mActA = mHoldA; mActB = mHoldB; end
      if (wrA) mHoldA = int'(wrData);
      if (wrB) mHoldB = int'(wrData);
      mOut = nOut; mArm = nArm;
    end
  end

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  // One clock; compare at the falling edge, then the caller drives new inputs
  task automatic tick();
    @(negedge clk);
    chk(curReq, "pwmOut", pwmOut, mOut);
    chk(curReq, "flag", flag, mFlag);
    if (rstN && pwmOut !== prevOut) edgesSeen++;
    prevOut = pwmOut;
  endtask

  task automatic cyc(input int v);
    timeBase = W'(v);
    tick();
  endtask

  task automatic sweep(input int peak, input int reps);
    for (int r = 0; r < reps; r++) begin
      for (int v = 1; v <= peak; v++) cyc(v);
      for (int v = peak - 1; v >= 2; v--) cyc(v);
    end
  endtask

  task automatic load(input int a, input int b);
    wrA = 1; wrData = W'(a); tick(); wrA = 0;
    wrB = 1; wrData = W'(b); tick(); wrB = 0;
  endtask

  task automatic pulseForceA(); forceA = 1; tick(); forceA = 0; endtask
  task automatic pulseForceB(); forceB = 1; tick(); forceB = 0; endtask
  task automatic pulseClr();    flagClr = 1; tick(); flagClr = 0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0; timeBase = W'(3); wrA = 0; wrB = 0; wrData = '0;
    leadMode = 0; edgePol = 0; flagBoth = 0;
    forceA = 0; forceB = 0; flagClr = 0;
    curReq = "R1";
    tick(); tick();
    chk("R1", "pwmOut reset", pwmOut, 1'b0);
    chk("R1", "flag reset", flag, 1'b0);
    rstN = 1;

    // R2: holding writes do nothing before a boundary
    curReq = "R2";
    edgePol = 1;
    timeBase = W'(8);
    load(10, 3);
    for (int i = 0; i < 4; i++) cyc(10);
    chk("R2", "no match before boundary", pwmOut, 1'b0);

    // R4: trail mode, active high
    curReq = "R4";
    sweep(20, 3);
    sweep(10, 2);   // A at the peak: one match per period
    sweep(20, 1);

    // R3: several dead-time lengths
    curReq = "R3";
    timeBase = W'(8);
    load(10, 1);
    sweep(20, 2);
    load(9, 6);
    sweep(20, 2);

    // R5: lead mode, both polarities
    curReq = "R5";
    leadMode = 1; edgePol = 0;
    load(12, 4);
    sweep(25, 3);
    edgePol = 1;
    sweep(25, 3);

    // R6: flag on both edges vs trailing only
    curReq = "R6";
    flagBoth = 1;
    pulseForceA();          // lead: inactive level, arm dropped
    pulseClr();
    chk("R6", "flag cleared", flag, 1'b0);
    for (int v = 1; v <= 20; v++) cyc(v);   // arms at 12, rises 4 later
    chk("R6", "leading edge with flagBoth=1", flag, 1'b1);
    flagBoth = 0;
    pulseForceA();
    pulseClr();
    for (int v = 1; v <= 20; v++) cyc(v);
    chk("R6", "leading edge with flagBoth=0", flag, 1'b0);
    for (int v = 19; v >= 2; v--) cyc(v);   // falls at 12
    chk("R6", "trailing edge sets flag", flag, 1'b1);
    sweep(25, 2);

    // R7: output keeps running with the flag left set
    curReq = "R7";
    edgesSeen = 0;
    sweep(25, 3);
    chk("R7", "edges with flag set", (edgesSeen >= 4), 1'b1);
    chk("R7", "flag still set", flag, 1'b1);

    // R8 / R9: force levels across mode and polarity
    for (int lm = 0; lm < 2; lm++) begin
      for (int ep = 0; ep < 2; ep++) begin
        leadMode = lm[0]; edgePol = ep[0];
        timeBase = W'(40);
        curReq = "R8";
        pulseForceA();
        chk("R8", "forceA level", pwmOut, lm[0] ? !ep[0] : ep[0]);
        curReq = "R9";
        pulseForceB();
        chk("R9", "forceB level", pwmOut, lm[0] ? ep[0] : !ep[0]);
      end
    end

    // R10: force drops a pending edge, sets no flag, wins over a match
    curReq = "R10";
    leadMode = 0; edgePol = 1; flagBoth = 1;
    timeBase = W'(8);
    load(10, 6);
    pulseForceB();          // trail: inactive
    pulseClr();
    for (int v = 1; v <= 20; v++) cyc(v);     // active at 10
    for (int v = 19; v >= 10; v--) cyc(v);    // armed at 10
    pulseClr();
    pulseForceA();          // trail: active level, arm dropped
    for (int i = 0; i < 10; i++) cyc(9);
    chk("R10", "pending edge dropped", pwmOut, 1'b1);
    pulseForceB();
    chk("R10", "force sets no flag", flag, 1'b0);
    timeBase = W'(10);
    pulseForceA();          // force beats the coinciding A match
    chk("R10", "force over match", pwmOut, 1'b1);
    sweep(20, 2);

    // R11: saturating counter never reaches a B value of 0
    curReq = "R11";
    flagBoth = 0;
    timeBase = W'(8);
    load(10, 0);
    pulseForceB();
    for (int v = 1; v <= 20; v++) cyc(v);
    for (int v = 19; v >= 10; v--) cyc(v);
    for (int i = 0; i < 300; i++) cyc(15);
    chk("R11", "no edge after saturation", pwmOut, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule